// File: doc/BRIEF.md
# Dual-Clause MDIO Management Controller

This block is a register-programmed master for the two-wire PHY management bus. It supports both the original short-frame format and the extended format, which uses a separate address frame. Software sets the clock divider, the preamble switch and the framing mode in a configuration register. It places 16 bits of payload in a data register. It then writes a command word carrying an operation code, a 5-bit PHY address and a 5-bit register or device address. The controller builds the frame, divides the system clock down to produce the management clock, and shifts the bits out.

The meaning of the operation code depends on the framing mode. Read frames release the data line for the turnaround and the 16 returned bits. Those bits are captured into a read-result register. While a frame is on the wire, a busy flag is visible in the top bit of the data register. Software polls that flag before issuing the next command. A command written while the flag is set has no effect. Sequencing the address frame and the data frame of an extended access is left to software.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, mdc is 0 and mdio_oe is 0. The configuration register reads 0x0001_0027 (half-period field 39, preamble on, short framing). The busy flag, the read-valid flag and the read-pending flag are all 0.
- R2: Each low phase and each high phase of mdc lasts `H+1` system clocks. `H` is the configuration register field bits [7:0].
- R3: When configuration bit 16 is 1, every frame starts with 32 driven 1 bits. When bit 16 is 0, the frame starts directly with the start field.
- R4: When configuration bit 17 is 0, the controller uses short framing. Command op 0 sends a write frame (start 01, code 01). Command op 1 sends a read frame (start 01, code 10). Ops 2 and 3 are ignored, and no frame is sent.
- R5: When configuration bit 17 is 1, the controller uses extended framing with start 00. Op 0 sends an address frame (code 00) whose 16 payload bits come from the data register. Op 1 sends a write frame (code 01). Op 3 sends a read frame (code 11). Op 2 is ignored.
- R6: The command word places the register or device address at bits [4:0], the PHY address at bits [9:5] and the op at bits [17:16]. After the start and code fields, the frame carries the PHY address and then the register or device address, each MSB first.
- R7: In write and address frames, mdio is driven with 1, 0 for the turnaround and then with data register bits [15:0], MSB first. In read frames, mdio_oe is 0 for the turnaround and for all 16 data bits.
- R8: mdio_o and mdio_oe change only at the system clock edge where mdc falls, or where a frame starts while mdc is low. They are stable while mdc is high.
- R9: In a read frame, mdio_i is sampled at each rising edge of mdc during the 16 data bits, MSB first. When the frame ends, the read-result register holds the data in bits [15:0] and has the valid flag (bit 30) set.
- R10: Bit 31 of the data register (address 2) is 1 exactly while a frame is in progress. Bit 31 of the read-result register (address 3) is 1 only during a read frame. The valid flag is cleared when a read frame starts.
- R11: A command written while a frame is in progress is ignored. The running frame and the stored command (address 1 readback) stay unchanged.
- R12: The register addresses are: 0 for configuration, 1 for command (reads back the last accepted command), 2 for data, and 3 for the read result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register address |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data (combinational on csr_addr) |
| mdio_i | input | 1 | Sampled level of the management data line |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data value when driving |
| mdio_oe | output | 1 | Management data drive enable |

## Verification
The half-period property assumes that software leaves the divider field unchanged while a frame runs. The stimulus writes the configuration register only after the bench model shows the line idle. The assertions also assume that mdio_i is driven by the PHY only while the controller releases the line. The bench therefore ties mdio_i to mdio_o while mdio_oe is 1, and it feeds the modelled PHY reply only while the line is released. Commands that collide with a running frame are issued deliberately, and only in the middle of a frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} phase_e;

    localparam logic [1:0] ADR_CFG  = 2'd0;
    localparam logic [1:0] ADR_CMD  = 2'd1;
    localparam logic [1:0] ADR_DATA = 2'd2;
    localparam logic [1:0] ADR_RES  = 2'd3;

    localparam int CFG_PRE_BIT = 16;
    localparam int CFG_EXT_BIT = 17;
    localparam int PRE_LEN     = 32;
    localparam int FRAME_LEN   = 32;
    localparam int TA_FIRST    = 14;
    localparam int DATA_FIRST  = 16;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    assign tick = run && (cnt_q == half_div);

    always_comb begin
        cnt_d = cnt_q;
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/mdio_frame_fmt.sv
module mdio_frame_fmt (
    input  logic        ext_mode,
    input  logic [1:0]  op,
    input  logic [4:0]  phy,
    input  logic [4:0]  rega,
    input  logic [15:0] payload,
    output logic [31:0] frame,
    output logic        is_read,
    output logic        op_ok
);
    logic [1:0] start_f, code_f;

    always_comb begin
        start_f = ext_mode ? 2'b00 : 2'b01;
        code_f  = 2'b00;
        is_read = 1'b0;
        op_ok   = 1'b1;
        if (!ext_mode) begin
            case (op)
                2'd0:    code_f = 2'b01;
                2'd1:    begin code_f = 2'b10; is_read = 1'b1; end
                default: op_ok = 1'b0;
            endcase
        end else begin
            case (op)
                2'd0:    code_f = 2'b00;
                2'd1:    code_f = 2'b01;
                2'd3:    begin code_f = 2'b11; is_read = 1'b1; end
                default: op_ok = 1'b0;
            endcase
        end
        if (is_read) frame = {start_f, code_f, phy, rega, 2'b00, 16'h0000};
        else         frame = {start_f, code_f, phy, rega, 2'b10, payload};
    end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl #(
    parameter int DIV_W   = 8,
    parameter int DIV_RST = 39
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        csr_wr,
    input  logic [1:0]  csr_addr,
    input  logic [31:0] csr_wdata,
    output logic [31:0] csr_rdata,
    input  logic        mdio_i,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe
);
    import mdio_pkg::*;

    localparam int IDX_W = 7;
    localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(FRAME_LEN - 1);
    localparam logic [IDX_W-1:0] LAST_LONG  = IDX_W'(PRE_LEN + FRAME_LEN - 1);
    localparam logic [IDX_W-1:0] DATA_SHORT = IDX_W'(DATA_FIRST);
    localparam logic [IDX_W-1:0] DATA_LONG  = IDX_W'(PRE_LEN + DATA_FIRST);

    typedef struct packed {
        phase_e           ph;
        logic             mdc;
        logic             mdo;
        logic             moe;
        logic [IDX_W-1:0] idx;
        logic             pre;
        logic             rd;
        logic [31:0]      frame;
        logic [15:0]      sh;
        logic [DIV_W-1:0] div;
        logic             cpre;
        logic             ext;
        logic [15:0]      wdat;
        logic [1:0]       op;
        logic [4:0]       phy;
        logic [4:0]       rega;
        logic [15:0]      rdat;
        logic             rvalid;
        logic             rpend;
    } st_t;

    st_t st_d, st_q;

    logic             tick;
    logic             busy;
    logic             rd_pend;
    logic [DIV_W-1:0] cfg_div;
    logic [11:0]      cmd_last;
    logic [31:0]      fmt_frame;
    logic             fmt_rd, fmt_ok;
    logic             in_data;
    logic [IDX_W-1:0] last_idx;
    logic [IDX_W-1:0] nxt_idx;
    logic             unused_hi;

    assign unused_hi = ^csr_wdata[31:18];
    assign busy      = (st_q.ph != PH_IDLE);
    assign rd_pend   = st_q.rpend;
    assign cfg_div   = st_q.div;
    assign cmd_last  = {st_q.op, st_q.phy, st_q.rega};

    function automatic logic [1:0] drive_at(input logic [IDX_W-1:0] i, input logic pre,
                                            input logic [31:0] fr, input logic rd);
        logic [IDX_W-1:0] fi;
        if (pre && (i < IDX_W'(PRE_LEN))) return 2'b11;
        fi = pre ? (i - IDX_W'(PRE_LEN)) : i;
        if (rd && (fi >= IDX_W'(TA_FIRST))) return 2'b00;
        return {1'b1, fr[5'd31 - fi[4:0]]};
    endfunction

    mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .half_div (st_q.div),
        .tick     (tick)
    );

    mdio_frame_fmt u_fmt (
        .ext_mode (st_q.ext),
        .op       (csr_wdata[17:16]),
        .phy      (csr_wdata[9:5]),
        .rega     (csr_wdata[4:0]),
        .payload  (st_q.wdat),
        .frame    (fmt_frame),
        .is_read  (fmt_rd),
        .op_ok    (fmt_ok)
    );

    assign last_idx = st_q.pre ? LAST_LONG : LAST_SHORT;
    assign nxt_idx  = st_q.idx + 1'b1;
    assign in_data  = st_q.rd && (st_q.idx >= (st_q.pre ? DATA_LONG : DATA_SHORT));

    always_comb begin
        st_d = st_q;
        if (csr_wr) begin
            case (csr_addr)
                ADR_CFG: begin
                    st_d.div  = csr_wdata[DIV_W-1:0];
                    st_d.cpre = csr_wdata[CFG_PRE_BIT];
                    st_d.ext  = csr_wdata[CFG_EXT_BIT];
                end
                ADR_CMD: begin
                    if (!busy && fmt_ok) begin
                        st_d.op    = csr_wdata[17:16];
                        st_d.phy   = csr_wdata[9:5];
                        st_d.rega  = csr_wdata[4:0];
                        st_d.frame = fmt_frame;
                        st_d.rd    = fmt_rd;
                        st_d.pre   = st_q.cpre;
                        st_d.idx   = '0;
                        st_d.ph    = PH_LOW;
                        st_d.mdc   = 1'b0;
                        {st_d.moe, st_d.mdo} = drive_at('0, st_q.cpre, fmt_frame, fmt_rd);
                        if (fmt_rd) begin
                            st_d.rpend  = 1'b1;
                            st_d.rvalid = 1'b0;
                        end
                    end
                end
                ADR_DATA: st_d.wdat = csr_wdata[15:0];
                default: ;
            endcase
        end

        case (st_q.ph)
            PH_LOW: begin
                if (tick) begin
                    st_d.mdc = 1'b1;
                    st_d.ph  = PH_HIGH;
                    if (in_data) st_d.sh = {st_q.sh[14:0], mdio_i};
                end
            end
            PH_HIGH: begin
                if (tick) begin
                    st_d.mdc = 1'b0;
                    if (st_q.idx == last_idx) begin
                        st_d.ph  = PH_IDLE;
                        st_d.moe = 1'b0;
                        st_d.mdo = 1'b0;
                        if (st_q.rd) begin
                            st_d.rdat   = st_q.sh;
                            st_d.rvalid = 1'b1;
                            st_d.rpend  = 1'b0;
                        end
                    end else begin
                        st_d.idx = nxt_idx;
                        st_d.ph  = PH_LOW;
                        {st_d.moe, st_d.mdo} = drive_at(nxt_idx, st_q.pre, st_q.frame, st_q.rd);
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.ph   <= PH_IDLE;
            st_q.div  <= DIV_W'(DIV_RST);
            st_q.cpre <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (csr_addr)
            ADR_CFG:  csr_rdata = {14'b0, st_q.ext, st_q.cpre, 16'(st_q.div)};
            ADR_CMD:  csr_rdata = {14'b0, st_q.op, 6'b0, st_q.phy, st_q.rega};
            ADR_DATA: csr_rdata = {busy, 15'b0, st_q.wdat};
            default:  csr_rdata = {st_q.rpend, st_q.rvalid, 14'b0, st_q.rdat};
        endcase
    end

    assign mdc     = st_q.mdc;
    assign mdio_o  = st_q.mdo;
    assign mdio_oe = st_q.moe;
endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mdc,
    input logic             mdio_oe,
    input logic             mdio_o,
    input logic             busy,
    input logic             rd_pend,
    input logic             csr_wr,
    input logic [1:0]       csr_addr,
    input logic [DIV_W-1:0] half_div,
    input logic [11:0]      cmd_last
);
    logic [DIV_W:0] ph_cnt_q;
    logic           mdc_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_cnt_q   <= '0;
            mdc_prev_q <= 1'b0;
        end else begin
            ph_cnt_q   <= (mdc != mdc_prev_q) ? '0 : ph_cnt_q + 1'b1;
            mdc_prev_q <= mdc;
        end
    end

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    p_rd_pend_in_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pend |-> busy);

    p_hold_while_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

    p_high_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc_prev_q && !mdc) |-> (ph_cnt_q == {1'b0, half_div}));

    p_cmd_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && csr_wr && csr_addr == 2'd1) |=> $stable(cmd_last));
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk #(.DIV_W(DIV_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .mdc      (mdc),
    .mdio_oe  (mdio_oe),
    .mdio_o   (mdio_o),
    .busy     (busy),
    .rd_pend  (rd_pend),
    .csr_wr   (csr_wr),
    .csr_addr (csr_addr),
    .half_div (cfg_div),
    .cmd_last (cmd_last)
);

// File: tb/mdio_mgmt_ctrl_tb_top.sv
module mdio_mgmt_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wr = 1'b0;
    logic [1:0]  csr_addr = 2'd2;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        mdio_i;
    logic        mdc, mdio_o, mdio_oe;
    logic        rsp_bit = 1'b0;

    int total = 0;
    int bad = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    assign mdio_i = mdio_oe ? mdio_o : rsp_bit;

    mdio_mgmt_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .mdio_i(mdio_i),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    typedef struct packed { logic mdc; logic oe; logic o; logic rsp; } ent_t;
    ent_t exp_q[$];
    int   m_div = 39;
    bit   m_pre = 1;
    bit   m_ext = 0;
    logic [15:0] m_wd = 0;
    logic [15:0] m_rsp = 0;

    task automatic push_bit(input bit oe, input bit v, input bit r);
        for (int k = 0; k < m_div + 1; k++) exp_q.push_back('{1'b0, oe, v, r});
        for (int k = 0; k < m_div + 1; k++) exp_q.push_back('{1'b1, oe, v, r});
    endtask

    task automatic model_cmd(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg);
        logic [1:0] st, code;
        bit rd;
        rd = 0;
        if (!m_ext) begin
            st = 2'b01;
            if (op == 0) code = 2'b01;
            else if (op == 1) begin code = 2'b10; rd = 1; end
            else return;
        end else begin
            st = 2'b00;
            if (op == 0) code = 2'b00;
            else if (op == 1) code = 2'b01;
            else if (op == 3) begin code = 2'b11; rd = 1; end
            else return;
        end
        if (m_pre) for (int i = 0; i < 32; i++) push_bit(1, 1, 0);
        for (int i = 1; i >= 0; i--) push_bit(1, st[i], 0);
        for (int i = 1; i >= 0; i--) push_bit(1, code[i], 0);
        for (int i = 4; i >= 0; i--) push_bit(1, phy[i], 0);
        for (int i = 4; i >= 0; i--) push_bit(1, rg[i], 0);
        if (rd) begin
            push_bit(0, 0, 0);
            push_bit(0, 0, 0);
            for (int i = 15; i >= 0; i--) push_bit(0, 0, m_rsp[i]);
        end else begin
            push_bit(1, 1, 0);
            push_bit(1, 0, 0);
            for (int i = 15; i >= 0; i--) push_bit(1, m_wd[i], 0);
        end
    endtask

    always @(posedge clk) begin
        bit was_busy;
        if (rst_n) begin
            was_busy = exp_q.size() > 0;
            if (was_busy) void'(exp_q.pop_front());
            if (csr_wr) begin
                case (csr_addr)
                    2'd0: begin m_div = int'(csr_wdata[7:0]); m_pre = csr_wdata[16]; m_ext = csr_wdata[17]; end
                    2'd1: if (!was_busy) model_cmd(csr_wdata[17:16], csr_wdata[9:5], csr_wdata[4:0]);
                    2'd2: m_wd = csr_wdata[15:0];
                    default: ;
                endcase
            end
        end
    end

    always @(posedge clk) begin
        ent_t e;
        #2;
        if (rst_n) begin
            e = (exp_q.size() > 0) ? exp_q[0] : '0;
            rsp_bit = e.rsp;
            total++;
            if (mdc !== e.mdc || mdio_oe !== e.oe || (e.oe && mdio_o !== e.o)) begin
                bad++;
                $display("FAIL %s waveform t=%0t act mdc/oe/o=%b%b%b exp=%b%b%b",
                         cur_req, $time, mdc, mdio_oe, mdio_o, e.mdc, e.oe, e.o);
            end
            if (csr_addr == 2'd2) begin
                total++;
                if (csr_rdata[31] !== (exp_q.size() > 0)) begin
                    bad++;
                    $display("FAIL R10 busy flag act=%b exp=%b", csr_rdata[31], exp_q.size() > 0);
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic csr_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_wr = 1'b0; csr_addr = 2'd2;
    endtask

    task automatic csr_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        csr_addr = a;
        #1 d = csr_rdata;
        csr_addr = 2'd2;
    endtask

    task automatic wait_idle();
        while (exp_q.size() > 0) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    function automatic logic [31:0] cmd_w(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg);
        return {14'b0, op, 6'b0, phy, rg};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        repeat (2) @(posedge clk);

        cur_req = "R1";
        csr_read(2'd0, rv); check(rv == 32'h0001_0027, "R1 R12 cfg reset", rv, 32'h0001_0027);
        csr_read(2'd2, rv); check(rv[31] == 1'b0, "R1 busy at reset", rv, 32'h0);
        csr_read(2'd3, rv); check(rv == 32'h0, "R1 result at reset", rv, 32'h0);

        cur_req = "R4";
        csr_write(2'd0, 32'h0001_0001);
        csr_write(2'd2, 32'h0000_A5C3);
        csr_write(2'd1, cmd_w(2'd0, 5'h11, 5'h06));
        csr_read(2'd2, rv); check(rv == 32'h8000_A5C3, "R10 busy during write", rv, 32'h8000_A5C3);
        wait_idle();
        csr_read(2'd1, rv); check(rv == cmd_w(2'd0, 5'h11, 5'h06), "R12 cmd readback", rv, cmd_w(2'd0, 5'h11, 5'h06));

        cur_req = "R9";
        m_rsp = 16'hBEEF;
        csr_write(2'd1, cmd_w(2'd1, 5'h03, 5'h1F));
        repeat (20) @(posedge clk);
        csr_read(2'd3, rv); check(rv[31:30] == 2'b10, "R10 read pending", rv, 32'h8000_0000);
        wait_idle();
        csr_read(2'd3, rv); check(rv == 32'h4000_BEEF, "R9 short read result", rv, 32'h4000_BEEF);

        cur_req = "R4";
        csr_write(2'd1, cmd_w(2'd2, 5'h01, 5'h01));
        repeat (6) @(posedge clk);
        csr_read(2'd2, rv); check(rv[31] == 1'b0, "R4 op2 ignored", rv, 32'h0);
        csr_read(2'd1, rv); check(rv == cmd_w(2'd0, 5'h03, 5'h1F) || rv == cmd_w(2'd1, 5'h03, 5'h1F),
                                  "R4 op2 not stored", rv, cmd_w(2'd1, 5'h03, 5'h1F));

        cur_req = "R3";
        csr_write(2'd0, 32'h0000_0001);
        csr_write(2'd2, 32'h0000_0F31);
        csr_write(2'd1, cmd_w(2'd0, 5'h1E, 5'h15));
        wait_idle();

        cur_req = "R5";
        csr_write(2'd0, 32'h0003_0003);
        csr_write(2'd2, 32'h0000_1234);
        csr_write(2'd1, cmd_w(2'd0, 5'h02, 5'h07));
        wait_idle();
        cur_req = "R7";
        csr_write(2'd2, 32'h0000_C001);
        csr_write(2'd1, cmd_w(2'd1, 5'h02, 5'h07));
        wait_idle();
        cur_req = "R2";
        m_rsp = 16'h0F0F;
        csr_write(2'd1, cmd_w(2'd3, 5'h02, 5'h07));
        wait_idle();
        csr_read(2'd3, rv); check(rv == 32'h4000_0F0F, "R9 extended read result", rv, 32'h4000_0F0F);
        cur_req = "R5";
        csr_write(2'd1, cmd_w(2'd2, 5'h02, 5'h07));
        repeat (6) @(posedge clk);
        csr_read(2'd2, rv); check(rv[31] == 1'b0, "R5 op2 ignored", rv, 32'h0);

        cur_req = "R11";
        csr_write(2'd0, 32'h0001_0001);
        csr_write(2'd2, 32'h0000_5AA5);
        csr_write(2'd1, cmd_w(2'd0, 5'h05, 5'h09));
        repeat (8) @(posedge clk);
        csr_write(2'd1, cmd_w(2'd1, 5'h1A, 5'h02));
        wait_idle();
        csr_read(2'd1, rv); check(rv == 32'h0000_00A9, "R11 busy cmd dropped", rv, 32'h0000_00A9);
        csr_read(2'd3, rv); check(rv == 32'h4000_0F0F, "R11 result untouched", rv, 32'h4000_0F0F);

        cur_req = "R6";
        m_rsp = 16'h8001;
        csr_write(2'd1, cmd_w(2'd1, 5'h10, 5'h01));
        wait_idle();
        csr_read(2'd3, rv); check(rv == 32'h4000_8001, "R6 R9 read edge bits", rv, 32'h4000_8001);
        csr_read(2'd0, rv); check(rv == 32'h0001_0001, "R12 cfg readback", rv, 32'h0001_0001);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule